// File: doc/BRIEF.md
# Power-Management Function Configuration Decoder

This block is the configuration-side front end of a power-management PCI function. It holds two relocatable I/O base registers, a 128-byte power-management window and a 16-byte SMBus window, each with its own enable bit in a separate control byte. Dword-addressed configuration writes arrive with per-byte lane enables. The block merges the written lanes into the stored value, drops the address bits that fall inside the window, and always returns bit 0 of each base register as 1. Each cycle it compares an I/O address against both windows and raises one hit line per enabled window.

The same block forms the SCI interrupt level. It does this from the PM1 event status and enable words of the function. The level is driven only while the interrupt-pin configuration byte is nonzero. A separate output tells the timer logic whether overflow tracking should be armed. The timer counter, the SMBus engine and the APM logic live elsewhere.

Top module: `pmfn_cfg_decoder`

## Requirements
- R1: After reset, the PM base dword (byte offset 0x48, dword 0x12) and the SMBus base dword (byte offset 0x90, dword 0x24) each read 0x00000001. The control dwords at 0x40 and 0xD0 (dwords 0x10 and 0x34) read zero. The interrupt-pin byte (offset 0x3D, lane 1 of dword 0x0F) reads the PIN_RST value, 0x01 by default. No window hits.
- R2: The PM base register keeps only address bits 15:7 of what is written. Bits 31:16 and 6:1 read 0, and bit 0 reads 1.
- R3: The SMBus base register keeps only address bits 15:4. Bits 31:16 and 3:1 read 0, and bit 0 reads 1.
- R4: A write to a base register updates only the enabled lanes among lanes 0 and 1. A write that enables only lanes 2 and 3 leaves the readback unchanged.
- R5: pm_hit is 1 exactly when bit 7 of config byte 0x41 (lane 1 of dword 0x10) is set and io_addr lies in the 128 bytes starting at the PM base.
- R6: smb_hit is 1 exactly when bit 0 of config byte 0xD2 (lane 2 of dword 0x34) is set and io_addr lies in the 16 bytes starting at the SMBus base.
- R7: A write to byte 0xD2 stores only its low four bits. The upper nibble reads back as 0.
- R8: The SCI level is 1 when any of four PM1 bits is set in both pm1_sts and pm1_en: bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (RTC alarm). All other bits have no effect.
- R9: sci_irq is forced to 0 while the interrupt-pin byte is zero. This byte is writable through lane 1 of dword 0x0F.
- R10: tmr_arm is 1 exactly when pm1_en bit 0 is set and pm1_sts bit 0 is clear.
- R11: A write with no lane enabled, or a write to a dword that holds none of the block's registers, leaves every readback unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe, one cycle per write |
| cfg_dw | input | 6 | Dword index of the configuration write |
| cfg_be | input | 4 | Byte-lane enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rd_dw | input | 6 | Dword index for the combinational readback |
| cfg_rdata | output | 32 | Readback of the selected dword |
| io_addr | input | ADDR_W | I/O cycle address to decode |
| pm_hit | output | 1 | io_addr falls in the enabled PM window |
| smb_hit | output | 1 | io_addr falls in the enabled SMBus window |
| pm1_sts | input | 16 | PM1 event status word |
| pm1_en | input | 16 | PM1 event enable word |
| sci_irq | output | 1 | SCI interrupt level |
| tmr_arm | output | 1 | Arm timer-overflow tracking |

## Verification
The bench uses the default parameters: a 16-bit I/O address, a 128-byte PM window, a 16-byte SMBus window, and the usual register offsets. Because the windows are small, the bench can probe the first and last byte of each window and the byte on either side of it. Because the PM and SMBus control bytes sit in different lanes of different dwords, the bench can check that lanes are kept separate. It also applies lane-2/3-only writes and writes with no lane enabled, and it sweeps each SCI source bit on its own and against the pin gate.

// File: rtl/pmfn_pkg.sv
package pmfn_pkg;

    // PM1 event bit positions that can raise SCI
    localparam int SCI_TMR_BIT    = 0;
    localparam int SCI_GLBL_BIT   = 5;
    localparam int SCI_PWRBTN_BIT = 8;
    localparam int SCI_RTC_BIT    = 10;

    typedef struct packed {
        logic        en;
        logic [5:0]  dw;
        logic [3:0]  be;
        logic [31:0] data;
    } cfg_wr_t;

endpackage

// File: rtl/pmfn_bar_slot.sv
module pmfn_bar_slot
    import pmfn_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter int         WIN_LOG2 = 7,
    parameter logic [5:0] BAR_DW   = 6'h12,
    localparam int        BASE_W   = ADDR_W - WIN_LOG2
) (
    input  cfg_wr_t            wr,
    input  logic [BASE_W-1:0]  base_q,
    input  logic               win_en,
    input  logic [ADDR_W-1:0]  io_addr,
    output logic [BASE_W-1:0]  base_d,
    output logic               hit,
    output logic [31:0]        rd_word
);
    localparam int LANES = ADDR_W / 8;

    logic              sel;
    logic [ADDR_W-1:0] cur_full;
    logic [ADDR_W-1:0] merged;

    assign sel      = wr.en && (wr.dw == BAR_DW);
    assign cur_full = {base_q, {WIN_LOG2{1'b0}}};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[8*l +: 8] = (sel && wr.be[l]) ? wr.data[8*l +: 8]
                                                    : cur_full[8*l +: 8];
    end

    // Low window-offset bits are dropped on every store
    assign base_d  = merged[ADDR_W-1:WIN_LOG2];
    assign hit     = win_en && (io_addr[ADDR_W-1:WIN_LOG2] == base_q);
    assign rd_word = {{(32-ADDR_W){1'b0}}, base_q, {(WIN_LOG2-1){1'b0}}, 1'b1};

    logic unused_slot;
    assign unused_slot = ^{merged[WIN_LOG2-1:0], wr.data, wr.be};

endmodule

// File: rtl/pmfn_sci_gen.sv
module pmfn_sci_gen
    import pmfn_pkg::*;
(
    input  logic [15:0] sts,
    input  logic [15:0] en,
    input  logic [7:0]  int_pin,
    output logic        sci,
    output logic        tmr_arm
);
    localparam logic [15:0] SRC_MASK = (16'd1 << SCI_TMR_BIT)
                                     | (16'd1 << SCI_GLBL_BIT)
                                     | (16'd1 << SCI_PWRBTN_BIT)
                                     | (16'd1 << SCI_RTC_BIT);

    logic level;

    assign level   = |(sts & en & SRC_MASK);
    assign sci     = level && (int_pin != 8'h00);
    assign tmr_arm = en[SCI_TMR_BIT] && !sts[SCI_TMR_BIT];

endmodule

// File: rtl/pmfn_cfg_decoder.sv
module pmfn_cfg_decoder
    import pmfn_pkg::*;
#(
    parameter int         ADDR_W       = 16,
    parameter int         PM_WIN_LOG2  = 7,
    parameter int         SMB_WIN_LOG2 = 4,
    parameter logic [7:0] PM_BAR_OFS   = 8'h48,
    parameter logic [7:0] SMB_BAR_OFS  = 8'h90,
    parameter logic [7:0] PM_EN_OFS    = 8'h41,
    parameter int         PM_EN_BIT    = 7,
    parameter logic [7:0] SMB_EN_OFS   = 8'hD2,
    parameter int         SMB_EN_BIT   = 0,
    parameter int         SMB_CTL_W    = 4,
    parameter logic [7:0] PIN_OFS      = 8'h3D,
    parameter logic [7:0] PIN_RST      = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [5:0]        cfg_dw,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    input  logic [5:0]        cfg_rd_dw,
    output logic [31:0]       cfg_rdata,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              pm_hit,
    output logic              smb_hit,
    input  logic [15:0]       pm1_sts,
    input  logic [15:0]       pm1_en,
    output logic              sci_irq,
    output logic              tmr_arm
);
    localparam int         PM_BASE_W   = ADDR_W - PM_WIN_LOG2;
    localparam int         SMB_BASE_W  = ADDR_W - SMB_WIN_LOG2;
    localparam logic [5:0] PM_BAR_DW   = PM_BAR_OFS[7:2];
    localparam logic [5:0] SMB_BAR_DW  = SMB_BAR_OFS[7:2];
    localparam logic [5:0] PM_EN_DW    = PM_EN_OFS[7:2];
    localparam int         PM_EN_LANE  = int'(PM_EN_OFS[1:0]);
    localparam logic [5:0] SMB_EN_DW   = SMB_EN_OFS[7:2];
    localparam int         SMB_EN_LANE = int'(SMB_EN_OFS[1:0]);
    localparam logic [5:0] PIN_DW      = PIN_OFS[7:2];
    localparam int         PIN_LANE    = int'(PIN_OFS[1:0]);

    typedef struct packed {
        logic [PM_BASE_W-1:0]  pm_base;
        logic [SMB_BASE_W-1:0] smb_base;
        logic [7:0]            pm_ctl;
        logic [SMB_CTL_W-1:0]  smb_ctl;
        logic [7:0]            int_pin;
    } state_t;

    state_t  st_d, st_q;
    cfg_wr_t wr;

    logic [PM_BASE_W-1:0]  pm_base_nx;
    logic [SMB_BASE_W-1:0] smb_base_nx;
    logic [31:0]           pm_rd, smb_rd;

    assign wr = '{en: cfg_wr_en, dw: cfg_dw, be: cfg_be, data: cfg_wdata};

    pmfn_bar_slot #(
        .ADDR_W   (ADDR_W),
        .WIN_LOG2 (PM_WIN_LOG2),
        .BAR_DW   (PM_BAR_DW)
    ) u_pm_slot (
        .wr      (wr),
        .base_q  (st_q.pm_base),
        .win_en  (st_q.pm_ctl[PM_EN_BIT]),
        .io_addr (io_addr),
        .base_d  (pm_base_nx),
        .hit     (pm_hit),
        .rd_word (pm_rd)
    );

    pmfn_bar_slot #(
        .ADDR_W   (ADDR_W),
        .WIN_LOG2 (SMB_WIN_LOG2),
        .BAR_DW   (SMB_BAR_DW)
    ) u_smb_slot (
        .wr      (wr),
        .base_q  (st_q.smb_base),
        .win_en  (st_q.smb_ctl[SMB_EN_BIT]),
        .io_addr (io_addr),
        .base_d  (smb_base_nx),
        .hit     (smb_hit),
        .rd_word (smb_rd)
    );

    pmfn_sci_gen u_sci (
        .sts     (pm1_sts),
        .en      (pm1_en),
        .int_pin (st_q.int_pin),
        .sci     (sci_irq),
        .tmr_arm (tmr_arm)
    );

    always_comb begin
        st_d          = st_q;
        st_d.pm_base  = pm_base_nx;
        st_d.smb_base = smb_base_nx;
        if (wr.en && wr.dw == PM_EN_DW && wr.be[PM_EN_LANE])
            st_d.pm_ctl = wr.data[8*PM_EN_LANE +: 8];
        if (wr.en && wr.dw == SMB_EN_DW && wr.be[SMB_EN_LANE])
            st_d.smb_ctl = wr.data[8*SMB_EN_LANE +: SMB_CTL_W];
        if (wr.en && wr.dw == PIN_DW && wr.be[PIN_LANE])
            st_d.int_pin = wr.data[8*PIN_LANE +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pm_base: '0, smb_base: '0, pm_ctl: '0,
                      smb_ctl: '0, int_pin: PIN_RST};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_rd_dw == PM_BAR_DW)  cfg_rdata = cfg_rdata | pm_rd;
        if (cfg_rd_dw == SMB_BAR_DW) cfg_rdata = cfg_rdata | smb_rd;
        if (cfg_rd_dw == PM_EN_DW)
            cfg_rdata = cfg_rdata | (32'(st_q.pm_ctl) << (8*PM_EN_LANE));
        if (cfg_rd_dw == SMB_EN_DW)
            cfg_rdata = cfg_rdata | (32'(st_q.smb_ctl) << (8*SMB_EN_LANE));
        if (cfg_rd_dw == PIN_DW)
            cfg_rdata = cfg_rdata | (32'(st_q.int_pin) << (8*PIN_LANE));
    end

    AST_PM_HIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        pm_hit |-> st_q.pm_ctl[PM_EN_BIT]); // R5

    AST_SMB_HIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        smb_hit |-> st_q.smb_ctl[SMB_EN_BIT]); // R6

    AST_SCI_PIN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        sci_irq |-> (st_q.int_pin != 8'h00)); // R9

    AST_TMR_ARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_arm |-> (pm1_en[SCI_TMR_BIT] && !pm1_sts[SCI_TMR_BIT])); // R10

    AST_PM_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr_en && cfg_dw == PM_BAR_DW && |cfg_be[1:0])
        |=> $stable(st_q.pm_base)); // R11

    AST_SMB_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr_en && cfg_dw == SMB_EN_DW && cfg_be[SMB_EN_LANE])
        |=> $stable(st_q.smb_ctl)); // R7

endmodule

// File: tb/pmfn_cfg_decoder_bench.sv
`timescale 1ns/1ps
module pmfn_cfg_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [5:0]  cfg_dw = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [5:0]  cfg_rd_dw = '0;
    logic [31:0] cfg_rdata;
    logic [15:0] io_addr = '0;
    logic        pm_hit, smb_hit;
    logic [15:0] pm1_sts = '0;
    logic [15:0] pm1_en = '0;
    logic        sci_irq, tmr_arm;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pmfn_cfg_decoder u_pmfn_cfg_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_dw(cfg_dw),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rd_dw(cfg_rd_dw),
        .cfg_rdata(cfg_rdata), .io_addr(io_addr), .pm_hit(pm_hit),
        .smb_hit(smb_hit), .pm1_sts(pm1_sts), .pm1_en(pm1_en),
        .sci_irq(sci_irq), .tmr_arm(tmr_arm)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [5:0] dw, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_be = '0;
    endtask

    task automatic read_chk(string req, logic [5:0] dw, logic [31:0] exp);
        cfg_rd_dw = dw;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic io_chk(string req, logic [15:0] a, logic exp_pm, logic exp_smb);
        io_addr = a;
        #1;
        check(req, {30'd0, pm_hit, smb_hit}, {30'd0, exp_pm, exp_smb});
    endtask

    task automatic sci_chk(string req, logic [15:0] s, logic [15:0] e,
                           logic exp_sci, logic exp_arm);
        pm1_sts = s; pm1_en = e;
        #1;
        check(req, {30'd0, sci_irq, tmr_arm}, {30'd0, exp_sci, exp_arm});
    endtask

    task automatic t_reset();
        read_chk("R1 pm base", 6'h12, 32'h0000_0001);
        read_chk("R1 smb base", 6'h24, 32'h0000_0001);
        read_chk("R1 pm ctl", 6'h10, 32'h0);
        read_chk("R1 smb ctl", 6'h34, 32'h0);
        read_chk("R1 pin", 6'h0F, 32'h0000_0100);
        io_chk("R1 no hit", 16'h0000, 1'b0, 1'b0);
    endtask

    task automatic t_pm_base();
        cfg_write(6'h12, 4'hF, 32'hFFFF_FFFF);
        read_chk("R2 all ones", 6'h12, 32'h0000_FF81);
        cfg_write(6'h12, 4'hF, 32'h1234_047E);
        read_chk("R2 masked", 6'h12, 32'h0000_0401);
    endtask

    task automatic t_smb_base();
        cfg_write(6'h24, 4'hF, 32'hABCD_1237);
        read_chk("R3 masked", 6'h24, 32'h0000_1231);
    endtask

    task automatic t_lanes();
        cfg_write(6'h24, 4'b1100, 32'hFFFF_0000);
        read_chk("R4 upper lanes", 6'h24, 32'h0000_1231);
        cfg_write(6'h24, 4'b0010, 32'h0000_56FF);
        read_chk("R4 lane1 only", 6'h24, 32'h0000_5631);
    endtask

    task automatic t_pm_window();
        io_chk("R5 disabled", 16'h0400, 1'b0, 1'b0);
        cfg_write(6'h10, 4'b0010, 32'h0000_8000);
        read_chk("R5 ctl read", 6'h10, 32'h0000_8000);
        io_chk("R5 first", 16'h0400, 1'b1, 1'b0);
        io_chk("R5 last", 16'h047F, 1'b1, 1'b0);
        io_chk("R5 above", 16'h0480, 1'b0, 1'b0);
        io_chk("R5 below", 16'h03FF, 1'b0, 1'b0);
        cfg_write(6'h10, 4'b0010, 32'h0000_7F00);
        io_chk("R5 bit7 clear", 16'h0400, 1'b0, 1'b0);
    endtask

    task automatic t_smb_window();
        io_chk("R6 disabled", 16'h5630, 1'b0, 1'b0);
        cfg_write(6'h34, 4'b0100, 32'h00FF_0000);
        read_chk("R7 low nibble kept", 6'h34, 32'h000F_0000);
        io_chk("R6 first", 16'h5630, 1'b0, 1'b1);
        io_chk("R6 last", 16'h563F, 1'b0, 1'b1);
        io_chk("R6 above", 16'h5640, 1'b0, 1'b0);
        io_chk("R6 below", 16'h562F, 1'b0, 1'b0);
        cfg_write(6'h34, 4'b0100, 32'h00FE_0000);
        read_chk("R7 nibble E", 6'h34, 32'h000E_0000);
        io_chk("R6 bit0 clear", 16'h5630, 1'b0, 1'b0);
    endtask

    task automatic t_sci();
        sci_chk("R8 timer", 16'h0001, 16'h0001, 1'b1, 1'b0);
        sci_chk("R8 glbl", 16'h0020, 16'h0020, 1'b1, 1'b0);
        sci_chk("R8 pwrbtn", 16'h0100, 16'h0100, 1'b1, 1'b0);
        sci_chk("R8 rtc", 16'h0400, 16'h0400, 1'b1, 1'b0);
        sci_chk("R8 other bits", 16'hFADE, 16'hFADE & 16'hFADE & ~16'h0521, 1'b0, 1'b0);
        sci_chk("R8 pending not enabled", 16'h0521, 16'h0000, 1'b0, 1'b0);
        sci_chk("R8 enabled not pending", 16'h0000, 16'h0520, 1'b0, 1'b0);
    endtask

    task automatic t_pin_gate();
        cfg_write(6'h0F, 4'b0010, 32'h0000_0000);
        read_chk("R9 pin zero", 6'h0F, 32'h0);
        sci_chk("R9 suppressed", 16'h0500, 16'h0500, 1'b0, 1'b0);
        cfg_write(6'h0F, 4'b0010, 32'h0000_0200);
        sci_chk("R9 restored", 16'h0500, 16'h0500, 1'b1, 1'b0);
    endtask

    task automatic t_tmr_arm();
        sci_chk("R10 armed", 16'h0000, 16'h0001, 1'b0, 1'b1);
        sci_chk("R10 pending", 16'h0001, 16'h0001, 1'b1, 1'b0);
        sci_chk("R10 disabled", 16'h0000, 16'h0000, 1'b0, 1'b0);
    endtask

    task automatic t_ignored();
        cfg_write(6'h12, 4'b0000, 32'hFFFF_FFFF);
        read_chk("R11 no lanes", 6'h12, 32'h0000_0401);
        cfg_write(6'h13, 4'hF, 32'hFFFF_FFFF);
        read_chk("R11 other dword pm", 6'h12, 32'h0000_0401);
        read_chk("R11 other dword smb", 6'h24, 32'h0000_5631);
        read_chk("R11 unmapped reads 0", 6'h13, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pm_base();
        t_smb_base();
        t_lanes();
        t_pm_window();
        t_smb_window();
        t_sci();
        t_pin_gate();
        t_tmr_arm();
        t_ignored();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule